// File: doc/BRIEF.md
# I2C Register-Access Target

This block lets an I2C host read and write an internal 8-bit register space through an 8-bit register pointer. SCL and SDA pass through a two-flop synchronizer clocked by a fast system clock. Start, repeated start and stop are found from the synchronized levels. The target answers only at 7-bit address 0x34. It pulls SDA low through an open-drain enable, where `sda_oe_o` = 1 means "drive low".

A write transaction works as follows. The first byte after the address sets the pointer. Every later byte goes out as a one-cycle write strobe to the register the pointer selects, and the pointer then moves up by one.

A read works like this: the host sets the pointer in a write phase, then issues a repeated start and the address with R/W = 1. The target then shifts out the addressed register, MSB first. Each byte it sends produces a one-cycle read strobe, and the pointer moves up by one. The register array returns data combinationally on `reg_rdata_i` for `reg_addr_o`.

A hold output stops the event queue and event counter from updating while an addressed host has the pointer on their registers. The pointer keeps its value across a stop.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset `sda_oe_o`, `reg_wr_o`, `reg_rd_o` and `hold_o` are 0 and the pointer (`reg_addr_o`) is 0x00.
- R2: An address byte of 0x34 with R/W = 0 (byte 0x68) or R/W = 1 (byte 0x69) is acknowledged by pulling SDA low in the ninth clock. Any other address gets no acknowledge and issues no strobe. That byte and every later byte are then ignored, with no acknowledge, until the next start or stop.
- R3: The first byte after an address with R/W = 0 loads the pointer, is acknowledged, and issues no write strobe.
- R4: Each later byte of a write is acknowledged and issues exactly one single-cycle `reg_wr_o` pulse, with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte.
- R5: The pointer increments by one, modulo 256, in the cycle after every write or read strobe, so a multibyte write fills consecutive registers (0xFF is followed by 0x00).
- R6: After a repeated start and address 0x69, the target pulses `reg_rd_o` once and shifts out the selected register MSB first. Write and read strobes never coincide.
- R7: When the host acknowledges a read byte, the next register (pointer + 1) follows. When the host gives no acknowledge, the target releases SDA and drives nothing more until a start or stop.
- R8: `sda_oe_o` changes only while SCL is low. It stays stable while SCL is high.
- R9: The pointer survives a stop, so a read with no pointer-set phase begins at the last pointer value.
- R10: `hold_o` is 1 while the target has been addressed since the last stop and the pointer lies in the event window 0x20..0x21. It is 0 otherwise, and 0 shortly after a stop.
- R11: A stop or start is legal at any bit. A stop in the middle of a data byte aborts it with no write strobe, and the pointer is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, many times the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_wr_o | output | 1 | Single-cycle register write strobe |
| reg_rd_o | output | 1 | Single-cycle register read strobe |
| reg_addr_o | output | 8 | Register pointer |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o`, combinational |
| hold_o | output | 1 | Freezes event queue and counter updates |

## Verification
The bench covers the following corner cases and the faulty behaviour each one exposes:
- A multibyte write that crosses 0xFF. A pointer without proper 8-bit wrap, or one that steps before the strobe, writes the wrong registers.
- An address mismatch followed by further bytes. A target that re-arms on byte boundaries would acknowledge or write them.
- A stop in the middle of a data byte. A design that commits partial bytes would emit a spurious write.
- A host NACK followed by an extra clock. A target that keeps shifting would pull SDA low.
- A read with no pointer-set phase, and pointer walks into and out of the event window. These catch a pointer reset on stop and a hold that ignores the pointer or outlives the transaction.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BIT_CNT_W = $clog2(BYTE_W + 1);

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX_LOAD,
    ST_TX,
    ST_TX_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, sda_s, scl_d, sda_d;

  // idle bus is high: reset the chain to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s      = scl_pipe[STAGES-1];
  assign sda_s      = sda_pipe[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h34
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sda_i,
  input  logic  scl_rise_i,
  input  logic  scl_fall_i,
  input  logic  start_i,
  input  logic  stop_i,
  input  byte_t rdata_i,
  output logic  sda_oe_o,
  output logic  wr_o,
  output logic  rd_o,
  output logic  ptr_ld_o,
  output byte_t data_o,
  output logic  sel_set_o,
  output logic  sel_clr_o
);
  localparam logic [BIT_CNT_W-1:0] FULL = BIT_CNT_W'(BYTE_W);

  tgt_state_e           state_q;
  logic [BIT_CNT_W-1:0] cnt_q;
  byte_t                sh_q;
  logic                 rw_q, first_q, nack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      rw_q      <= 1'b0;
      first_q   <= 1'b0;
      nack_q    <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_o      <= 1'b0;
      rd_o      <= 1'b0;
      ptr_ld_o  <= 1'b0;
      data_o    <= '0;
      sel_set_o <= 1'b0;
      sel_clr_o <= 1'b0;
    end else begin
      wr_o      <= 1'b0;
      rd_o      <= 1'b0;
      ptr_ld_o  <= 1'b0;
      sel_set_o <= 1'b0;
      sel_clr_o <= 1'b0;
      if (stop_i) begin
        state_q   <= ST_IDLE;
        sda_oe_o  <= 1'b0;
        sel_clr_o <= 1'b1;
      end else if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == FULL) begin
              if (sh_q[BYTE_W-1:1] == TGT_ADDR) begin
                sda_oe_o  <= 1'b1;
                rw_q      <= sh_q[0];
                sel_set_o <= 1'b1;
                state_q   <= ST_ADDR_ACK;
              end else begin
                sel_clr_o <= 1'b1;
                state_q   <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q    <= '0;
              sda_oe_o <= 1'b0;
              if (rw_q) begin
                rd_o    <= 1'b1;
                state_q <= ST_TX_LOAD;
              end else begin
                first_q <= 1'b1;
                state_q <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == FULL) begin
              sda_oe_o <= 1'b1;
              data_o   <= sh_q;
              state_q  <= ST_RX_ACK;
              if (first_q) begin
                ptr_ld_o <= 1'b1;
                first_q  <= 1'b0;
              end else begin
                wr_o <= 1'b1;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              cnt_q    <= '0;
              state_q  <= ST_RX;
            end
          end
          ST_TX_LOAD: begin
            // rd strobe is high this cycle, rdata_i is valid
            sh_q     <= rdata_i;
            sda_oe_o <= ~rdata_i[BYTE_W-1];
            cnt_q    <= BIT_CNT_W'(1);
            state_q  <= ST_TX;
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == FULL) begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_TX_ACK;
              end else begin
                sda_oe_o <= ~sh_q[BYTE_W-2];
                sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
                cnt_q    <= cnt_q + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) begin
              nack_q <= sda_i;
            end else if (scl_fall_i) begin
              if (nack_q) begin
                state_q <= ST_IDLE;
              end else begin
                rd_o    <= 1'b1;
                state_q <= ST_TX_LOAD;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_ptr_hold.sv
module i2c_ptr_hold
  import i2c_tgt_pkg::*;
#(
  parameter byte_t EVT_LO = 8'h20,
  parameter byte_t EVT_HI = 8'h21
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ptr_ld_i,
  input  logic  step_i,
  input  byte_t data_i,
  input  logic  sel_set_i,
  input  logic  sel_clr_i,
  output byte_t ptr_o,
  output logic  hold_o
);
  byte_t ptr_q;
  logic  active_q;
  logic  in_win;

  assign in_win = (ptr_q >= EVT_LO) && (ptr_q <= EVT_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      active_q <= 1'b0;
      hold_o   <= 1'b0;
    end else begin
      if (ptr_ld_i)    ptr_q <= data_i;
      else if (step_i) ptr_q <= ptr_q + 1'b1;
      if (sel_clr_i)      active_q <= 1'b0;
      else if (sel_set_i) active_q <= 1'b1;
      hold_o <= active_q && in_win && !sel_clr_i;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  TGT_ADDR    = 7'h34,
  parameter byte_t       EVT_LO      = 8'h20,
  parameter byte_t       EVT_HI      = 8'h21,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       reg_wr_o,
  output logic       reg_rd_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  input  logic [7:0] reg_rdata_i,
  output logic       hold_o
);
  logic  sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic  ptr_ld, sel_set, sel_clr;
  byte_t data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_tgt_fsm #(.TGT_ADDR(TGT_ADDR)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .rdata_i    (reg_rdata_i),
    .sda_oe_o   (sda_oe_o),
    .wr_o       (reg_wr_o),
    .rd_o       (reg_rd_o),
    .ptr_ld_o   (ptr_ld),
    .data_o     (data),
    .sel_set_o  (sel_set),
    .sel_clr_o  (sel_clr)
  );

  i2c_ptr_hold #(.EVT_LO(EVT_LO), .EVT_HI(EVT_HI)) i_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ptr_ld_i  (ptr_ld),
    .step_i    (reg_wr_o | reg_rd_o),
    .data_i    (data),
    .sel_set_i (sel_set),
    .sel_clr_i (sel_clr),
    .ptr_o     (reg_addr_o),
    .hold_o    (hold_o)
  );

  assign reg_wdata_o = data;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_oe_o,
  input logic       reg_wr_o,
  input logic       reg_rd_o,
  input logic [7:0] reg_addr_o,
  input logic       hold_o
);
  // R1
  rst_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!sda_oe_o && !reg_wr_o && !reg_rd_o && !hold_o && reg_addr_o == 8'h00));

  // R8
  sda_stable_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

  // R4
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  // R5
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o || reg_rd_o) |=> (reg_addr_o == $past(reg_addr_o) + 8'd1));

  // R6
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_o && reg_rd_o));
endmodule

bind i2c_reg_target i2c_reg_target_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .reg_wr_o   (reg_wr_o),
  .reg_rd_o   (reg_rd_o),
  .reg_addr_o (reg_addr_o),
  .hold_o     (hold_o)
);

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam int Q = 50;  // quarter SCL period in clocks, SCL ~1.25 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  wire        sda_line;
  logic       sda_oe, wr, rd, hold;
  logic [7:0] addr, wdata, rdata;

  logic [7:0] dev_mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ptr = 8'h00;
  logic [7:0] rd_val;
  int n_chk = 0, n_fail = 0, r8_viol = 0;
  bit done = 1'b0;

  typedef struct {bit is_rd; logic [7:0] a; logic [7:0] d; string req;} ev_t;
  ev_t exp_q[$];

  always #2 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;
  assign rdata    = dev_mem[addr];

  i2c_reg_target i_i2c_reg_target (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .reg_wr_o    (wr),
    .reg_rd_o    (rd),
    .reg_addr_o  (addr),
    .reg_wdata_o (wdata),
    .reg_rdata_i (rdata),
    .hold_o      (hold)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pop expected accesses as strobes appear
  always @(negedge clk) begin
    if (rst_n && (wr || rd)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R11", "unexpected strobe", {rd, wr, addr, wdata}, 0);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        check(e.is_rd == rd && e.a == addr && (rd || e.d == wdata), e.req, "reg access",
              {rd, addr, wdata}, {e.is_rd, e.a, e.d});
      end
      if (wr) dev_mem[addr] = wdata;
    end
  end

  // R8 observer
  logic scl_p = 1'b1, oe_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && scl_p && sda_oe != oe_p) r8_viol++;
    scl_p = scl;
    oe_p  = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wbit(input bit b);
    m_sda = b; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
  endtask

  task automatic rbit(output bit b);
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic start_c();
    if (!scl) begin m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); end
    m_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic stop_c();
    m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_chk(input logic [7:0] b, input bit exp_ack, input string req);
    bit nb;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(nb);
    check(!nb == exp_ack, req, "ack", !nb, exp_ack);
  endtask

  task automatic wr_data(input logic [7:0] d, input string req);
    exp_q.push_back('{1'b0, exp_ptr, d, req});
    exp_mem[exp_ptr] = d;
    exp_ptr++;
    send_chk(d, 1'b1, req);
  endtask

  task automatic set_ptr(input logic [7:0] p, input string req);
    start_c();
    send_chk(8'h68, 1'b1, "R2");
    send_chk(p, 1'b1, req);
    exp_ptr = p;
  endtask

  task automatic rd_push(input string req);
    exp_q.push_back('{1'b1, exp_ptr, exp_mem[exp_ptr], req});
    rd_val = exp_mem[exp_ptr];
    exp_ptr++;
  endtask

  task automatic rd_byte(input bit ack_it, input string req);
    logic [7:0] v, e;
    bit b;
    e = rd_val;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    check(v == e, req, "read data", v, e);
    if (ack_it) rd_push(req);
    wbit(!ack_it);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    bit b;
    for (int i = 0; i < 256; i++) begin
      dev_mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    tick(5); rst_n = 1'b1; tick(5);
    // R1 reset state
    check(sda_oe == 1'b0, "R1", "sda_oe", sda_oe, 0);
    check(hold == 1'b0, "R1", "hold", hold, 0);
    check(addr == 8'h00, "R1", "pointer", addr, 0);

    // single write: R3, R4
    set_ptr(8'h05, "R3");
    check(addr == 8'h05, "R3", "pointer loaded", addr, 8'h05);
    wr_data(8'hA5, "R4");
    stop_c();

    // multibyte write across 0xFF: R5
    set_ptr(8'hFE, "R5");
    check(hold == 1'b0, "R10", "hold outside window", hold, 0);
    wr_data(8'h11, "R5");
    wr_data(8'h22, "R5");
    wr_data(8'h33, "R5");
    stop_c();
    check(addr == 8'h01, "R5", "pointer wrap", addr, 8'h01);

    // pointer-set then repeated-start read, NACK: R6, R7
    set_ptr(8'h05, "R3");
    rd_push("R6");
    start_c();
    send_chk(8'h69, 1'b1, "R6");
    rd_byte(1'b0, "R6");
    check(sda_oe == 1'b0, "R7", "released after nack", sda_oe, 0);
    rbit(b);
    check(b == 1'b1, "R7", "no drive after nack", b, 1);
    stop_c();

    // read with host ACK continues at pointer+1: R7
    set_ptr(8'hFE, "R5");
    rd_push("R7");
    start_c();
    send_chk(8'h69, 1'b1, "R6");
    rd_byte(1'b1, "R7");
    rd_byte(1'b0, "R7");
    stop_c();

    // pointer kept across stop: R9
    rd_push("R9");
    start_c();
    send_chk(8'h69, 1'b1, "R9");
    rd_byte(1'b0, "R9");
    stop_c();

    // address mismatch: R2
    start_c();
    send_chk(8'h6A, 1'b0, "R2");
    send_chk(8'h10, 1'b0, "R2");
    send_chk(8'h99, 1'b0, "R2");
    stop_c();
    check(addr == 8'h01, "R2", "pointer untouched", addr, 8'h01);

    // stop in the middle of a data byte: R11
    set_ptr(8'h40, "R11");
    wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b1);
    stop_c();
    tick(5);
    check(addr == 8'h40, "R11", "pointer after abort", addr, 8'h40);

    // hold window: R10
    check(hold == 1'b0, "R10", "hold idle", hold, 0);
    set_ptr(8'h20, "R10");
    check(hold == 1'b1, "R10", "hold in window", hold, 1);
    wr_data(8'h77, "R10");
    check(hold == 1'b1, "R10", "hold at upper bound", hold, 1);
    wr_data(8'h78, "R10");
    check(hold == 1'b0, "R10", "hold past window", hold, 0);
    stop_c();
    set_ptr(8'h21, "R10");
    check(hold == 1'b1, "R10", "hold reselected", hold, 1);
    stop_c();
    tick(5);
    check(hold == 1'b0, "R10", "hold after stop", hold, 0);

    tick(20);
    check(exp_q.size() == 0, "R4", "missing accesses", exp_q.size(), 0);
    check(r8_viol == 0, "R8", "sda change while scl high", r8_viol, 0);
    done = 1'b1;
    finish_run();
  end
endmodule